// File: doc/BRIEF.md
# Piecewise-Linear Divisive Normalizer

This block is a per-pixel arithmetic pipeline for the normalization stage of a learned image codec. Each accepted pixel is processed in one of four modes: forward divisive normalization, its inverse, a per-channel affine scale (batch normalization) or a rectifier. The pipeline has a fixed latency. The block has no divider and no square-root unit. The inverse-square-root (or square-root) term is approximated by a 25-segment piecewise-linear curve. Each segment's slope and intercept are folded ahead of time into a coefficient pair (ĝ, b̂), so the forward path is y = x·(ĝ·x² + b̂).

Two coefficient banks each hold 25 segments. Bank 0 serves the forward transform and bank 1 serves the inverse transform. Every segment carries a breakpoint on the squared input. The banks are filled through a simple indexed write port. The affine mode reuses the same multiplier with the scale and offset that arrive alongside each pixel. All data are signed 16-bit fixed point. A per-pixel shift input sets the number of fraction bits, so one datapath serves layers with different binary-point positions.

Top module: `pwl_norm`

## Requirements
- R1: `valid_o` equals `valid_i` from exactly four clock edges earlier, in every mode, including back-to-back pixels and gaps.
- R2: While `rst_ni` is low, `valid_o` is 0 and `y_o` is 0.
- R3: Mode 2'b00 (forward) computes the result from bank 0 in three steps, all using arithmetic right shifts by f = `frac_i`. First, sq = (x·x) >>> f. Second, t = sat32(((ĝ·sq) >>> f) + b̂). Third, y = sat16((x·t) >>> f).
- R4: Mode 2'b01 (inverse) uses the same formula as R3, with the segment coefficients and breakpoints taken from bank 1.
- R5: The segment index is the count of entries i in 1..24 of the active bank whose signed 32-bit breakpoint is less than or equal to sq. The breakpoint of entry 0 is never compared. Segment index s selects the coefficient pair (ĝ, b̂) of entry s.
- R6: Mode 2'b10 (affine) gives y = sat16(sat32(((scale·x) >>> f) + offset)).
- R7: Mode 2'b11 (rectifier) gives y = x when x ≥ 0 and y = 0 otherwise.
- R8: The output clamps to the range [-32768, 32767], and the intermediate term t clamps to the signed 32-bit range. Neither value wraps.
- R9: When `tw_en_i` is high at a clock edge, the entry `tw_idx_i` of bank `tw_bank_i` takes the breakpoint, ĝ and b̂ values from the write port. A write with an index of 25 or more changes nothing.
- R10: While `valid_o` is low, `y_o` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Pixel strobe |
| mode_i | input | 2 | 00 forward, 01 inverse, 10 affine, 11 rectifier |
| frac_i | input | 4 | Fraction bit count (shift amount) |
| x_i | input | 16 | Signed pixel value |
| scale_i | input | 16 | Affine scale for this pixel's channel |
| offset_i | input | 16 | Affine offset for this pixel's channel |
| tw_en_i | input | 1 | Coefficient table write strobe |
| tw_bank_i | input | 1 | Bank select for the write |
| tw_idx_i | input | 5 | Segment index for the write |
| tw_brk_i | input | 32 | Segment breakpoint on sq |
| tw_gam_i | input | 16 | Folded ĝ for the segment |
| tw_bet_i | input | 16 | Folded b̂ for the segment |
| valid_o | output | 1 | Result strobe |
| y_o | output | 16 | Signed result |

## Verification
The assertions check on every cycle that the strobe is a four-cycle delayed copy of the input strobe, that the result holds steady when no result is flagged, that reset clears both outputs, and that the rectifier output matches the pixel seen four cycles earlier. Only the bench scenarios can show the arithmetic of the forward, inverse and affine modes. These scenarios cover the choice of segment at an exact breakpoint and one below it, saturation of both the 32-bit intermediate and the 16-bit output, and the fact that out-of-range table writes leave results unchanged.

// File: rtl/pwl_norm_pkg.sv
package pwl_norm_pkg;
  typedef enum logic [1:0] {
    MODE_GDN  = 2'b00,
    MODE_IGDN = 2'b01,
    MODE_BN   = 2'b10,
    MODE_RELU = 2'b11
  } norm_mode_e;
endpackage

// File: rtl/pwl_norm_seg_table.sv
module pwl_norm_seg_table #(
  parameter int DW    = 16,
  parameter int IW    = 32,
  parameter int NSEG  = 25,
  parameter int IDXW  = $clog2(NSEG),
  parameter int NBANK = 2,
  parameter int BW    = $clog2(NBANK)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [BW-1:0]          wbank_i,
  input  logic [IDXW-1:0]        widx_i,
  input  logic signed [IW-1:0]   wbrk_i,
  input  logic signed [DW-1:0]   wgam_i,
  input  logic signed [DW-1:0]   wbet_i,
  input  logic [BW-1:0]          rbank_i,
  input  logic signed [IW-1:0]   sq_i,
  output logic signed [DW-1:0]   gam_o,
  output logic signed [DW-1:0]   bet_o
);
  logic signed [IW-1:0] brk_q [NBANK][NSEG];
  logic signed [DW-1:0] gam_q [NBANK][NSEG];
  logic signed [DW-1:0] bet_q [NBANK][NSEG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NBANK; b++) begin
        for (int s = 0; s < NSEG; s++) begin
          brk_q[b][s] <= '0;
          gam_q[b][s] <= '0;
          bet_q[b][s] <= '0;
        end
      end
    end else if (we_i && (int'(widx_i) < NSEG)) begin
      brk_q[wbank_i][widx_i] <= wbrk_i;
      gam_q[wbank_i][widx_i] <= wgam_i;
      bet_q[wbank_i][widx_i] <= wbet_i;
    end
  end

  // entry 0 has no lower boundary to test
  logic [NSEG-1:0] hit;
  assign hit[0] = 1'b0;
  for (genvar s = 1; s < NSEG; s++) begin : g_cmp
    assign hit[s] = (brk_q[rbank_i][s] <= sq_i);
  end

  logic [IDXW-1:0] seg;
  always_comb begin
    seg = '0;
    for (int s = 1; s < NSEG; s++) seg = seg + IDXW'(hit[s]);
  end

  assign gam_o = gam_q[rbank_i][seg];
  assign bet_o = bet_q[rbank_i][seg];
endmodule

// File: rtl/pwl_norm_out.sv
module pwl_norm_out
  import pwl_norm_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 32,
  parameter int FW = 4
) (
  input  norm_mode_e           mode_i,
  input  logic [FW-1:0]        frac_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [IW-1:0] t_i,
  output logic signed [DW-1:0] y_o
);
  localparam int PW = DW + IW;
  localparam logic signed [DW-1:0] YMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] YMIN = {1'b1, {(DW-1){1'b0}}};

  logic signed [PW-1:0] prod, prod_sh;
  logic signed [DW-1:0] mul_sat, aff_sat;
  logic                 mul_ovf, aff_ovf;

  assign prod    = PW'(x_i) * PW'(t_i);
  assign prod_sh = prod >>> frac_i;
  assign mul_ovf = !((&prod_sh[PW-1:DW-1]) || ~(|prod_sh[PW-1:DW-1]));
  assign mul_sat = mul_ovf ? (prod_sh[PW-1] ? YMIN : YMAX) : prod_sh[DW-1:0];
  assign aff_ovf = !((&t_i[IW-1:DW-1]) || ~(|t_i[IW-1:DW-1]));
  assign aff_sat = aff_ovf ? (t_i[IW-1] ? YMIN : YMAX) : t_i[DW-1:0];

  always_comb begin
    unique case (mode_i)
      MODE_BN:   y_o = aff_sat;
      MODE_RELU: y_o = x_i[DW-1] ? '0 : x_i;
      default:   y_o = mul_sat;
    endcase
  end
endmodule

// File: rtl/pwl_norm.sv
module pwl_norm
  import pwl_norm_pkg::*;
#(
  parameter int DW   = 16,
  parameter int IW   = 32,
  parameter int FW   = 4,
  parameter int NSEG = 25,
  parameter int IDXW = $clog2(NSEG)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [1:0]             mode_i,
  input  logic [FW-1:0]          frac_i,
  input  logic signed [DW-1:0]   x_i,
  input  logic signed [DW-1:0]   scale_i,
  input  logic signed [DW-1:0]   offset_i,
  input  logic                   tw_en_i,
  input  logic                   tw_bank_i,
  input  logic [IDXW-1:0]        tw_idx_i,
  input  logic signed [IW-1:0]   tw_brk_i,
  input  logic signed [DW-1:0]   tw_gam_i,
  input  logic signed [DW-1:0]   tw_bet_i,
  output logic                   valid_o,
  output logic signed [DW-1:0]   y_o
);
  localparam int PW = DW + IW;
  localparam int SW = PW + 1;
  localparam logic signed [IW-1:0] TMAX = {1'b0, {(IW-1){1'b1}}};
  localparam logic signed [IW-1:0] TMIN = {1'b1, {(IW-1){1'b0}}};

  // stage 1: square
  logic signed [2*DW-1:0] sq_full;
  assign sq_full = x_i * x_i;

  logic                 v1;
  norm_mode_e           m1;
  logic [FW-1:0]        f1;
  logic signed [DW-1:0] x1, sc1, of1;
  logic signed [IW-1:0] sq1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1 <= 1'b0; m1 <= MODE_GDN; f1 <= '0;
      x1 <= '0; sc1 <= '0; of1 <= '0; sq1 <= '0;
    end else begin
      v1  <= valid_i;
      m1  <= norm_mode_e'(mode_i);
      f1  <= frac_i;
      x1  <= x_i;
      sc1 <= scale_i;
      of1 <= offset_i;
      sq1 <= IW'(sq_full >>> frac_i);
    end
  end

  // stage 2: segment select and coefficient fetch
  logic signed [DW-1:0] gam_w, bet_w;

  pwl_norm_seg_table #(
    .DW(DW), .IW(IW), .NSEG(NSEG), .IDXW(IDXW), .NBANK(2), .BW(1)
  ) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tw_en_i),
    .wbank_i (tw_bank_i),
    .widx_i  (tw_idx_i),
    .wbrk_i  (tw_brk_i),
    .wgam_i  (tw_gam_i),
    .wbet_i  (tw_bet_i),
    .rbank_i (m1 == MODE_IGDN),
    .sq_i    (sq1),
    .gam_o   (gam_w),
    .bet_o   (bet_w)
  );

  logic                 v2;
  norm_mode_e           m2;
  logic [FW-1:0]        f2;
  logic signed [DW-1:0] x2, sc2, of2, g2, b2;
  logic signed [IW-1:0] sq2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v2 <= 1'b0; m2 <= MODE_GDN; f2 <= '0;
      x2 <= '0; sc2 <= '0; of2 <= '0; g2 <= '0; b2 <= '0; sq2 <= '0;
    end else begin
      v2 <= v1; m2 <= m1; f2 <= f1;
      x2 <= x1; sc2 <= sc1; of2 <= of1; sq2 <= sq1;
      g2 <= gam_w; b2 <= bet_w;
    end
  end

  // stage 3: shared multiply-add, affine mode swaps operands
  logic                 bn2;
  logic signed [DW-1:0] op_a, bias;
  logic signed [IW-1:0] op_b, t_sat;
  logic signed [PW-1:0] prod3, prod3_sh;
  logic signed [SW-1:0] sum3;
  logic                 ovf3;

  assign bn2      = (m2 == MODE_BN);
  assign op_a     = bn2 ? sc2 : g2;
  assign op_b     = bn2 ? IW'(x2) : sq2;
  assign bias     = bn2 ? of2 : b2;
  assign prod3    = PW'(op_a) * PW'(op_b);
  assign prod3_sh = prod3 >>> f2;
  assign sum3     = SW'(prod3_sh) + SW'(bias);
  assign ovf3     = !((&sum3[SW-1:IW-1]) || ~(|sum3[SW-1:IW-1]));
  assign t_sat    = ovf3 ? (sum3[SW-1] ? TMIN : TMAX) : sum3[IW-1:0];

  logic                 v3;
  norm_mode_e           m3;
  logic [FW-1:0]        f3;
  logic signed [DW-1:0] x3;
  logic signed [IW-1:0] t3;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v3 <= 1'b0; m3 <= MODE_GDN; f3 <= '0; x3 <= '0; t3 <= '0;
    end else begin
      v3 <= v2; m3 <= m2; f3 <= f2; x3 <= x2; t3 <= t_sat;
    end
  end

  // stage 4: final product, clamp, mode select
  logic signed [DW-1:0] y_w;

  pwl_norm_out #(.DW(DW), .IW(IW), .FW(FW)) u_out (
    .mode_i (m3),
    .frac_i (f3),
    .x_i    (x3),
    .t_i    (t3),
    .y_o    (y_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      y_o     <= '0;
    end else begin
      valid_o <= v3;
      if (v3) y_o <= y_w;
    end
  end
endmodule

// File: rtl/pwl_norm_chk.sv
module pwl_norm_chk #(
  parameter int DW = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic [1:0]           mode_i,
  input logic signed [DW-1:0] x_i,
  input logic                 valid_o,
  input logic signed [DW-1:0] y_o
);
  logic [2:0] warm_q;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 3'd4)  warm_q <= warm_q + 3'd1;
  end
  assign warm = (warm_q == 3'd4);

  // R2
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && y_o == '0));

  // R1
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> (valid_o == $past(valid_i, 4)));

  // R7
  relu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(valid_i, 4) && ($past(mode_i, 4) == 2'b11))
      |-> (y_o == (($signed($past(x_i, 4)) < 0) ? '0 : $past(x_i, 4))));

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(y_o));
endmodule

bind pwl_norm pwl_norm_chk #(.DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .mode_i  (mode_i),
  .x_i     (x_i),
  .valid_o (valid_o),
  .y_o     (y_o)
);

// File: tb/pwl_norm_tb.sv
module pwl_norm_tb;
  localparam int DW = 16, IW = 32, FW = 4, NSEG = 25, IDXW = 5;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic valid_i = 1'b0, tw_en_i = 1'b0, tw_bank_i = 1'b0;
  logic [1:0] mode_i = '0;
  logic [FW-1:0] frac_i = '0;
  logic signed [DW-1:0] x_i = '0, scale_i = '0, offset_i = '0;
  logic [IDXW-1:0] tw_idx_i = '0;
  logic signed [IW-1:0] tw_brk_i = '0;
  logic signed [DW-1:0] tw_gam_i = '0, tw_bet_i = '0;
  logic valid_o;
  logic signed [DW-1:0] y_o;

  pwl_norm u_dut (.*);

  always #5 clk_i = ~clk_i;

  int total = 0, bad = 0, cyc = 0, cur = 0;
  bit hv[8];
  longint hexp[8];
  string hreq[8];
  longint last_y = 0;
  longint brk_m[2][NSEG], gam_m[2][NSEG], bet_m[2][NSEG];

  function automatic longint sat(longint v, int n);
    longint mx = (longint'(1) <<< (n - 1)) - 1;
    longint mn = -(longint'(1) <<< (n - 1));
    return (v > mx) ? mx : ((v < mn) ? mn : v);
  endfunction

  function automatic longint model(int m, longint x, longint sc, longint of, int f);
    longint sq, t;
    int seg, b;
    if (m == 3) return (x < 0) ? 0 : x;
    if (m == 2) return sat(sat(((sc * x) >>> f) + of, 32), 16);
    b = m;
    sq = (x * x) >>> f;
    seg = 0;
    for (int i = 1; i < NSEG; i++) if (brk_m[b][i] <= sq) seg++;
    t = sat(((gam_m[b][seg] * sq) >>> f) + bet_m[b][seg], 32);
    return sat((x * t) >>> f, 16);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    int k;
    @(negedge clk_i);
    k = (cyc + 4) % 8;
    chk("R1", longint'(valid_o), longint'(hv[k]));
    if (hv[k]) begin
      chk(hreq[k], longint'(y_o), hexp[k]);
      last_y = hexp[k];
    end else begin
      chk("R10", longint'(y_o), last_y);
    end
    cur = cyc % 8;
    hv[cur] = 1'b0;
    valid_i = 1'b0;
    tw_en_i = 1'b0;
    cyc++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pixel(int m, int x, int sc, int of, int f, string req);
    tick();
    valid_i = 1'b1; mode_i = 2'(m); frac_i = FW'(f);
    x_i = DW'(x); scale_i = DW'(sc); offset_i = DW'(of);
    hv[cur] = 1'b1;
    hexp[cur] = model(m, x, sc, of, f);
    hreq[cur] = req;
  endtask

  task automatic twrite(int b, int idx, longint brk, int g, int bt);
    tick();
    tw_en_i = 1'b1; tw_bank_i = b[0]; tw_idx_i = IDXW'(idx);
    tw_brk_i = IW'(brk); tw_gam_i = DW'(g); tw_bet_i = DW'(bt);
    if (idx < NSEG) begin
      brk_m[b][idx] = brk; gam_m[b][idx] = g; bet_m[b][idx] = bt;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int m, x, f;
    longint acc;
    string tag;
    void'($urandom(32'd20240517));
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < NSEG; i++) begin
        brk_m[b][i] = 0; gam_m[b][i] = 0; bet_m[b][i] = 0;
      end
    for (int i = 0; i < 8; i++) begin hv[i] = 1'b0; hexp[i] = 0; hreq[i] = "R1"; end

    // R2 reset state
    repeat (3) @(negedge clk_i);
    chk("R2", longint'(valid_o), 0);
    chk("R2", longint'(y_o), 0);
    rst_ni = 1'b1;

    // R9 load both banks with random monotonic tables
    for (int b = 0; b < 2; b++) begin
      acc = 0;
      for (int i = 0; i < NSEG; i++) begin
        if (i > 0) acc += longint'($urandom_range(1, 4000));
        twrite(b, i, acc, int'($urandom_range(0, 4095)) - 2048,
               int'($urandom_range(0, 32767)) - 4096);
      end
    end
    idle(4);

    // random mixed-mode stream
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 3) == 0) begin
        tick();
        continue;
      end
      m = int'($urandom_range(0, 3));
      f = int'($urandom_range(0, 12));
      if (m < 2) x = int'($urandom_range(0, 16383)) - 8192;
      else       x = int'($signed(16'($urandom)));
      tag = (m == 0) ? "R3" : (m == 1) ? "R4" : (m == 2) ? "R6" : "R7";
      pixel(m, x, int'($signed(16'($urandom))), int'($signed(16'($urandom))), f, tag);
    end
    idle(6);

    // R5 directed segment boundaries: brk[i] = 100*i*i, g = 0, b = i+1
    for (int i = 0; i < NSEG; i++) twrite(0, i, 100 * i * i, 0, i + 1);
    idle(2);
    pixel(0, 30, 0, 0, 0, "R5");
    pixel(0, 29, 0, 0, 0, "R5");
    pixel(0, -30, 0, 0, 0, "R5");
    pixel(0, 0, 0, 0, 0, "R5");
    pixel(0, 250, 0, 0, 0, "R5");
    idle(5);
    chk("R5", longint'(y_o), 6250);

    // R9 out-of-range writes ignored, in-range write takes effect
    twrite(0, 25, 0, 0, 7000);
    twrite(0, 31, 0, 0, 7000);
    idle(2);
    pixel(0, 250, 0, 0, 0, "R9");
    pixel(0, 30, 0, 0, 0, "R9");
    twrite(0, 3, 900, 0, 50);
    idle(2);
    pixel(0, 30, 0, 0, 0, "R9");
    idle(5);
    chk("R9", longint'(y_o), 1500);

    // R8 saturation of output and intermediate
    pixel(2, 32767, 32767, 0, 0, "R8");
    pixel(2, -32768, 32767, 0, 0, "R8");
    pixel(2, 100, 32767, 32767, 0, "R8");
    idle(2);
    twrite(0, 24, 1000, 32767, 32767);
    idle(2);
    pixel(0, -32768, 0, 0, 0, "R8");
    pixel(0, 32767, 0, 0, 0, "R8");

    // R7 rectifier corners, back-to-back
    pixel(3, -1, 0, 0, 0, "R7");
    pixel(3, -32768, 0, 0, 0, "R7");
    pixel(3, 0, 0, 0, 0, "R7");
    pixel(3, 32767, 0, 0, 0, "R7");
    idle(8);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule